// File: doc/BRIEF.md
# Indirect Address/Data Register Bridge

This block gives a host a small window of 64-bit registers through which it reaches a much larger internal register space. The host first loads a 12-bit target offset into a pointer register. An access to the window's data register is then carried out on an internal request/response bus at that offset. The result of a read comes back to the host. The window also holds a sticky status register, which is cleared by writing ones, and two control slots that accept writes and ignore them.

Host accesses are always 8 bytes wide. The register index is the byte address shifted right by three. The host holds `hostValid`, its address and its data steady until it sees `hostReady`. Accesses to local registers finish in the same cycle. An access to the data register stalls until the internal side answers, and only one internal transaction is in flight at a time.

Top module: `ind_reg_bridge`

## Requirements
- R1: A write to index 0 (byte address 0x00) stores only bits [11:0] of the written value as the pointer. A read of index 0 returns the pointer zero-extended to 64 bits.
- R2: A read of index 1 (byte address 0x08) issues exactly one internal read (`intReqWrite`=0) at the pointer offset. The host receives `intRspData` of that response.
- R3: A write of index 1 issues exactly one internal write (`intReqWrite`=1) at the pointer offset, carrying the host write data unchanged.
- R4: A write to index 2 (byte address 0x10, status) clears every status bit that is 1 in the written value and leaves all other status bits unchanged.
- R5: An internal response with `intRspErr`=1 sets status bit 0.
- R6: Writes to indices 3 and 4 complete without `hostErr` and change no register; reads of them return 0.
- R7: A write to any index from 5 up completes with `hostErr`=1 and changes no register. A read of such an index returns 0 without error.
- R8: During a data-register access, `hostReady` stays low from the request until the cycle after the internal response. `intReqValid` is a single-cycle pulse, and no new request is issued before the response.
- R9: An access whose byte address has nonzero bits [2:0] is invalid. A write of this kind completes with `hostErr`=1 and no effect. A read of this kind returns 0. Neither kind issues an internal request.
- R10: Data-register accesses do not change the pointer (no auto-increment).
- R11: After reset the pointer and status read as 0 and no internal request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host access request, held until hostReady |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | ADDR_W (6) | Host byte address |
| hostWdata | input | DATA_W (64) | Host write data |
| hostRdata | output | DATA_W (64) | Read data, valid while hostReady is high |
| hostReady | output | 1 | Access completes this cycle |
| hostErr | output | 1 | Completed write was rejected |
| intReqValid | output | 1 | Internal request pulse |
| intReqWrite | output | 1 | Internal request is a write |
| intReqOffset | output | OFF_W (12) | Internal register offset (the pointer) |
| intReqData | output | DATA_W (64) | Internal write data |
| intRspValid | input | 1 | Internal response, at least one cycle after the request |
| intRspData | input | DATA_W (64) | Internal read data |
| intRspErr | input | 1 | Internal response reports an error |

## Verification
The assertions check the following on every cycle:
- the pointer taking the low 12 bits of each accepted pointer write;
- status bit 0 rising after an error response;
- the single-cycle request pulse, with `hostReady` held low while it is out;
- `hostErr` appearing only on a completed write.

The directed scenarios are needed for the rest:
- data values going through to the internal side and back;
- write-one-to-clear with mixed masks;
- the silent control slots;
- misaligned accesses issuing no internal request;
- the pointer surviving data accesses, since these span several transactions.

// File: rtl/ind_reg_bridge_pkg.sv
package ind_reg_bridge_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } bridgeState_t;

  // Window indices (byte address >> 3)
  localparam int IDX_PTR    = 0;
  localparam int IDX_DATA   = 1;
  localparam int IDX_STATUS = 2;
  localparam int IDX_CTLA   = 3;
  localparam int IDX_CTLB   = 4;

  typedef struct packed {
    logic ldPtr;     // load pointer from host data
    logic clrStatus; // write-one-to-clear status
    logic capRsp;    // capture internal response data
    logic setErr;    // set status bit 0
    logic selRsp;    // drive captured response to host
  } bridgeStrobe_t;

endpackage

// File: rtl/ind_reg_bridge_ctrl.sv
module ind_reg_bridge_ctrl
  import ind_reg_bridge_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostValid,
  input  logic             hostWrite,
  input  logic [IDX_W-1:0] hostIdx,
  input  logic             misaligned,
  input  logic             intRspValid,
  input  logic             intRspErr,
  output logic             hostReady,
  output logic             hostErr,
  output logic             intReqValid,
  output bridgeStrobe_t    strb
);

  bridgeState_t state, stateNxt;

  logic isData;
  assign isData = !misaligned && (hostIdx == IDX_W'(IDX_DATA));

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt    = state;
    hostReady   = 1'b0;
    hostErr     = 1'b0;
    intReqValid = 1'b0;
    strb        = '0;
    unique case (state)
      ST_IDLE: begin
        if (hostValid) begin
          if (isData) begin
            stateNxt = ST_ISSUE;
          end else begin
            hostReady = 1'b1;
            if (hostWrite) begin
              if (misaligned) begin
                hostErr = 1'b1;
              end else if (hostIdx == IDX_W'(IDX_PTR)) begin
                strb.ldPtr = 1'b1;
              end else if (hostIdx == IDX_W'(IDX_STATUS)) begin
                strb.clrStatus = 1'b1;
              end else if (hostIdx == IDX_W'(IDX_CTLA) ||
                           hostIdx == IDX_W'(IDX_CTLB)) begin
                hostErr = 1'b0;
              end else begin
                hostErr = 1'b1;
              end
            end
          end
        end
      end
      ST_ISSUE: begin
        intReqValid = 1'b1;
        stateNxt    = ST_WAIT;
      end
      ST_WAIT: begin
        if (intRspValid) begin
          strb.capRsp = 1'b1;
          strb.setErr = intRspErr;
          stateNxt    = ST_DONE;
        end
      end
      ST_DONE: begin
        hostReady   = 1'b1;
        strb.selRsp = 1'b1;
        stateNxt    = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/ind_reg_bridge_dp.sv
module ind_reg_bridge_dp
  import ind_reg_bridge_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 64,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  bridgeStrobe_t     strb,
  input  logic [IDX_W-1:0]  hostIdx,
  input  logic              misaligned,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] intRspData,
  output logic [OFF_W-1:0]  ptrReg,
  output logic [DATA_W-1:0] statusReg,
  output logic [DATA_W-1:0] hostRdata
);

  localparam int PAD_W = DATA_W - OFF_W;

  logic [DATA_W-1:0] rspReg;
  logic [DATA_W-1:0] localRd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrReg    <= '0;
      statusReg <= '0;
      rspReg    <= '0;
    end else begin
      if (strb.ldPtr)     ptrReg    <= hostWdata[OFF_W-1:0];
      if (strb.capRsp)    rspReg    <= intRspData;
      if (strb.clrStatus) statusReg <= statusReg & ~hostWdata;
      else if (strb.setErr) statusReg <= statusReg | DATA_W'(1);
    end
  end

  always_comb begin
    localRd = '0;
    if (!misaligned) begin
      if (hostIdx == IDX_W'(IDX_PTR))         localRd = {{PAD_W{1'b0}}, ptrReg};
      else if (hostIdx == IDX_W'(IDX_STATUS)) localRd = statusReg;
    end
  end

  assign hostRdata = strb.selRsp ? rspReg : localRd;

endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import ind_reg_bridge_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 64,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostValid,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostReady,
  output logic              hostErr,
  output logic              intReqValid,
  output logic              intReqWrite,
  output logic [OFF_W-1:0]  intReqOffset,
  output logic [DATA_W-1:0] intReqData,
  input  logic              intRspValid,
  input  logic [DATA_W-1:0] intRspData,
  input  logic              intRspErr
);

  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0]  hostIdx;
  logic              misaligned;
  bridgeStrobe_t     strb;
  logic [DATA_W-1:0] statusReg;

  assign hostIdx    = hostAddr[ADDR_W-1:3];
  assign misaligned = |hostAddr[2:0];

  ind_reg_bridge_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostValid(hostValid), .hostWrite(hostWrite),
    .hostIdx(hostIdx), .misaligned(misaligned),
    .intRspValid(intRspValid), .intRspErr(intRspErr),
    .hostReady(hostReady), .hostErr(hostErr),
    .intReqValid(intReqValid), .strb(strb)
  );

  ind_reg_bridge_dp #(.IDX_W(IDX_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hostIdx(hostIdx), .misaligned(misaligned),
    .hostWdata(hostWdata), .intRspData(intRspData),
    .ptrReg(intReqOffset), .statusReg(statusReg),
    .hostRdata(hostRdata)
  );

  // Host holds write flag and data steady for the whole stalled access
  assign intReqWrite = hostWrite;
  assign intReqData  = hostWdata;

endmodule

// File: rtl/ind_reg_bridge_chk.sv
module ind_reg_bridge_chk #(
  parameter int ADDR_W = 6,
  parameter int OFF_W  = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostValid,
  input logic              hostWrite,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [OFF_W-1:0]  wdLow,
  input logic              hostReady,
  input logic              hostErr,
  input logic              intReqValid,
  input logic [OFF_W-1:0]  intReqOffset,
  input logic              intRspValid,
  input logic              intRspErr,
  input logic              statusBit0
);

  assert_ptr_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && hostReady && hostWrite && hostAddr == '0)
      |=> (intReqOffset == $past(wdLow)));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (intRspValid && intRspErr && !intReqValid) |=> statusBit0);

  assert_req_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    intReqValid |=> !intReqValid);

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    intReqValid |-> !hostReady);

  assert_err_on_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    hostErr |-> (hostReady && hostWrite && hostValid));

  assert_no_req_after_reset_R11: assert property (@(posedge clk)
    $rose(rstN) |-> !intReqValid);

endmodule

bind ind_reg_bridge ind_reg_bridge_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .hostValid(hostValid), .hostWrite(hostWrite), .hostAddr(hostAddr),
  .wdLow(hostWdata[OFF_W-1:0]),
  .hostReady(hostReady), .hostErr(hostErr),
  .intReqValid(intReqValid), .intReqOffset(intReqOffset),
  .intRspValid(intRspValid), .intRspErr(intRspErr),
  .statusBit0(statusReg[0])
);

// File: tb/ind_reg_bridge_bench.sv
module ind_reg_bridge_bench;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 64;
  localparam int OFF_W  = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              hostValid = 1'b0;
  logic              hostWrite = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic [DATA_W-1:0] hostWdata = '0;
  logic [DATA_W-1:0] hostRdata;
  logic              hostReady, hostErr;
  logic              intReqValid, intReqWrite;
  logic [OFF_W-1:0]  intReqOffset;
  logic [DATA_W-1:0] intReqData;
  logic              intRspValid = 1'b0;
  logic [DATA_W-1:0] intRspData = '0;
  logic              intRspErr = 1'b0;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // responder model
  logic [DATA_W-1:0] mem [256];
  int          rspLat = 1;
  bit          injectErr = 0;
  int          reqCount = 0;
  logic        lastWrite;
  logic [OFF_W-1:0]  lastOff;
  logic [DATA_W-1:0] lastData;

  always #10 clk = ~clk;  // 50 MHz

  ind_reg_bridge u_ind_reg_bridge (.*);

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (intReqValid) begin
        reqCount++;
        lastWrite = intReqWrite;
        lastOff   = intReqOffset;
        lastData  = intReqData;
        if (intReqWrite) mem[intReqOffset[7:0]] = intReqData;
        for (int i = 1; i < rspLat; i++) @(posedge clk);
        @(negedge clk);
        intRspValid = 1'b1;
        intRspErr   = injectErr;
        intRspData  = mem[intReqOffset[7:0]];
        @(negedge clk);
        intRspValid = 1'b0;
        intRspErr   = 1'b0;
      end
    end
  end

  task automatic access(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                        output logic [DATA_W-1:0] rd, output logic er, output int cyc);
    @(negedge clk);
    hostValid = 1'b1; hostWrite = wr; hostAddr = a; hostWdata = wd;
    cyc = 0;
    forever begin
      #5;
      if (hostReady) begin
        rd = hostRdata; er = hostErr;
        break;
      end
      cyc++;
      @(negedge clk);
    end
    @(negedge clk);
    hostValid = 1'b0; hostWrite = 1'b0;
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] rd; logic er; int c;
    check("R11 no request", {63'd0, intReqValid}, 64'd0);
    access(0, 6'h00, 0, rd, er, c); check("R11 pointer", rd, 64'd0);
    access(0, 6'h10, 0, rd, er, c); check("R11 status", rd, 64'd0);
  endtask

  task automatic t_pointer();
    logic [DATA_W-1:0] rd; logic er; int c;
    access(1, 6'h00, 64'hFFFF_FFFF_FFFF_F5A3, rd, er, c);
    check("R1 no error", {63'd0, er}, 64'd0);
    access(0, 6'h00, 0, rd, er, c); check("R1 readback", rd, 64'h5A3);
  endtask

  task automatic t_data_write();
    logic [DATA_W-1:0] rd; logic er; int c; int n0;
    access(1, 6'h00, 64'h010, rd, er, c);
    rspLat = 2; n0 = reqCount;
    access(1, 6'h08, 64'hDEAD_BEEF_0123_4567, rd, er, c);
    check("R3 one request", 64'(reqCount - n0), 64'd1);
    check("R3 write flag", {63'd0, lastWrite}, 64'd1);
    check("R3 offset", {52'd0, lastOff}, 64'h010);
    check("R3 data", lastData, 64'hDEAD_BEEF_0123_4567);
    check("R8 stall cycles", 64'(c), 64'd4);
    access(0, 6'h00, 0, rd, er, c); check("R10 pointer kept", rd, 64'h010);
  endtask

  task automatic t_data_read();
    logic [DATA_W-1:0] rd; logic er; int c; int n0;
    mem[8'h44] = 64'h1122_3344_5566_7788;
    access(1, 6'h00, 64'h044, rd, er, c);
    rspLat = 3; n0 = reqCount;
    access(0, 6'h08, 0, rd, er, c);
    check("R2 data", rd, 64'h1122_3344_5566_7788);
    check("R2 read flag", {63'd0, lastWrite}, 64'd0);
    check("R2 offset", {52'd0, lastOff}, 64'h044);
    check("R2 one request", 64'(reqCount - n0), 64'd1);
    check("R8 stall cycles", 64'(c), 64'd5);
    access(0, 6'h08, 0, rd, er, c);
    check("R10 repeat read same offset", {52'd0, lastOff}, 64'h044);
    rspLat = 1;
  endtask

  task automatic t_status();
    logic [DATA_W-1:0] rd; logic er; int c;
    injectErr = 1;
    access(0, 6'h08, 0, rd, er, c);
    injectErr = 0;
    access(0, 6'h10, 0, rd, er, c); check("R5 status bit0 set", rd, 64'd1);
    access(1, 6'h10, 64'hFFFF_FFFF_FFFF_FFFE, rd, er, c);
    access(0, 6'h10, 0, rd, er, c); check("R4 zero bit keeps", rd, 64'd1);
    access(1, 6'h10, 64'd1, rd, er, c);
    access(0, 6'h10, 0, rd, er, c); check("R4 one bit clears", rd, 64'd0);
  endtask

  task automatic t_ctrl();
    logic [DATA_W-1:0] rd; logic er; int c;
    access(1, 6'h00, 64'h7AB, rd, er, c);
    access(1, 6'h18, '1, rd, er, c); check("R6 ctlA no error", {63'd0, er}, 64'd0);
    access(1, 6'h20, '1, rd, er, c); check("R6 ctlB no error", {63'd0, er}, 64'd0);
    access(0, 6'h18, 0, rd, er, c); check("R6 ctlA reads 0", rd, 64'd0);
    access(0, 6'h20, 0, rd, er, c); check("R6 ctlB reads 0", rd, 64'd0);
    access(0, 6'h00, 0, rd, er, c); check("R6 pointer untouched", rd, 64'h7AB);
    access(0, 6'h10, 0, rd, er, c); check("R6 status untouched", rd, 64'd0);
  endtask

  task automatic t_unknown();
    logic [DATA_W-1:0] rd; logic er; int c;
    access(1, 6'h28, 64'h123, rd, er, c); check("R7 write error", {63'd0, er}, 64'd1);
    access(1, 6'h38, 64'h456, rd, er, c); check("R7 write error top", {63'd0, er}, 64'd1);
    access(0, 6'h00, 0, rd, er, c); check("R7 pointer untouched", rd, 64'h7AB);
    access(0, 6'h30, 0, rd, er, c);
    check("R7 read value", rd, 64'd0);
    check("R7 read no error", {63'd0, er}, 64'd0);
  endtask

  task automatic t_misaligned();
    logic [DATA_W-1:0] rd; logic er; int c; int n0;
    n0 = reqCount;
    access(1, 6'h01, 64'h0FF, rd, er, c); check("R9 write error", {63'd0, er}, 64'd1);
    access(0, 6'h00, 0, rd, er, c); check("R9 pointer untouched", rd, 64'h7AB);
    access(0, 6'h09, 0, rd, er, c); check("R9 read zero", rd, 64'd0);
    access(1, 6'h0C, 64'h99, rd, er, c); check("R9 data write error", {63'd0, er}, 64'd1);
    check("R9 no request", 64'(reqCount - n0), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    t_reset();
    t_pointer();
    t_data_write();
    t_data_read();
    t_status();
    t_ctrl();
    t_unknown();
    t_misaligned();
    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule